// File: doc/BRIEF.md
# Enable/Ready Pipelined Clock-Crossing FIFO

This block carries data words from a write clock domain to an unrelated read clock domain. The writer offers at most one strobe per permission. A permission is held once after reset and again in every cycle where `wr_ready` is high. The strobe is either `wr_en`, which comes with a word on `wr_data` in the same cycle, or `wr_nen`, a "nothing to send" poll. The block answers each strobe with a one-cycle `wr_ready` pulse once it can take another word. The pulse passes through two write-clock registers, so the writer sees it two cycles after the strobe at the earliest. The writer can therefore push at most one word every other write cycle.

Each accepted word is held in a small write-side slot. Its occupancy crosses to the read domain as a single-bit toggle per slot, and the freeing of the slot comes back the same way. On the read side the word enters a chain of `DEPTH` stages and moves one stage per read cycle. It then leaves through two back-to-back registers that carry the word and its valid flag together. The reader takes a word on every read cycle in which `rd_valid` is high, and it can take words on consecutive cycles.

Each domain has its own active-low reset. The reset is applied at once and released through two flops clocked by that domain's clock.

Top module: `xclk_stage_fifo`

## Requirements
- R1: After reset release (two edges of each domain's clock), `wr_ready` and `rd_valid` are 0. The writer holds one permission and may strobe without waiting for `wr_ready`.
- R2: A word is taken only in a write cycle with `wr_en` high (`wr_data` sampled in that cycle). A cycle with neither strobe, or with `wr_nen`, adds nothing to the read side.
- R3: After a `wr_en` strobe, if another slot is free, `wr_ready` is high in exactly the second write cycle after the strobe. The pulse is one cycle wide.
- R4: After a `wr_nen` strobe while a slot is free, `wr_ready` is high in exactly the second write cycle after the strobe.
- R5: `wr_ready` never rises without an unanswered strobe, and never sooner than two cycles after it. When no slot is free, the strobe is held pending and answered later, once a slot frees.
- R6: Every word taken appears once on `rd_data` with `rd_valid` high, unchanged and in write order. `rd_valid` is never high with no word outstanding.
- R7: `rd_data` and `rd_valid` each come from two registers in series after the last stage. The read side can deliver words on consecutive read cycles.
- R8: `wr_en` and `wr_nen` are never high together. The writer strobes only while it holds a permission, which implies the current slot is free.
- R9: A word moves into a stage only when that stage is empty or emptying in the same cycle. The count of occupied stages changes only by words entering the first stage and leaving the last one.
- R10: While either reset input is low, that domain's outputs (`wr_ready`, or `rd_valid`) are 0 with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write domain clock |
| wrst_n | input | 1 | Write domain reset, active low |
| wr_en | input | 1 | Strobe: word on wr_data is offered this cycle |
| wr_nen | input | 1 | Strobe: nothing offered this cycle, asks for permission |
| wr_data | input | DW | Word qualified by wr_en |
| wr_ready | output | 1 | One-cycle pulse granting the next strobe |
| rclk | input | 1 | Read domain clock |
| rrst_n | input | 1 | Read domain reset, active low |
| rd_valid | output | 1 | rd_data carries a word this read cycle |
| rd_data | output | DW | Word delivered to the read side |

## Verification
Two things can fall in the same write cycle: a slot being filled by an accepted `wr_en`, and the return of another slot's release from the read domain. That timing decides whether the ready pulse comes on time or is held pending. The case is provoked by a burst of writes against a read clock eight times slower than the write clock, so that strobes meet releases that arrive one by one. It is judged in two ways. Every ready pulse must answer an unanswered strobe no sooner than two cycles after it, and at least one must come late. All words must still arrive unchanged, in order, and, once the ring has backed up, on consecutive read cycles.

// File: rtl/xclk_stage_fifo.sv
module xclk_stage_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 3
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          wr_en,
  input  logic          wr_nen,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ready,
  input  logic          rclk,
  input  logic          rrst_n,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LAST = DEPTH - 1;
  localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

  // ---------------- write domain ----------------
  logic [1:0]       wrs;
  logic             w_rst_n;
  logic [DW-1:0]    ring [DEPTH];
  logic [DEPTH-1:0] wtog, ack_m, ack_s;
  logic [AW-1:0]    wptr, wnext;
  logic             pend, rdy1, space_now, space_after, ready_or, accept;

  always_ff @(posedge wclk or negedge wrst_n)
    if (!wrst_n) wrs <= '0;
    else         wrs <= {wrs[0], 1'b1};
  assign w_rst_n = wrs[1];

  assign wnext       = (wptr == TOP) ? '0 : wptr + 1'b1;
  assign space_now   = ~(wtog[wptr] ^ ack_s[wptr]);
  assign space_after = (wnext != wptr) && ~(wtog[wnext] ^ ack_s[wnext]);
  assign ready_or    = (wr_en & space_after) | ((wr_nen | pend) & space_now);
  assign accept      = wr_en & space_now;

  always_ff @(posedge wclk or negedge w_rst_n)
    if (!w_rst_n) begin
      wptr     <= '0;
      wtog     <= '0;
      ack_m    <= '0;
      ack_s    <= '0;
      pend     <= 1'b0;
      rdy1     <= 1'b0;
      wr_ready <= 1'b0;
    end else begin
      ack_m    <= rtog;
      ack_s    <= ack_m;
      rdy1     <= ready_or;
      wr_ready <= rdy1;
      pend     <= wr_en ? ~space_after : ((wr_nen | pend) & ~space_now);
      if (accept) begin
        wtog[wptr] <= ~wtog[wptr];
        wptr       <= wnext;
      end
    end

  always_ff @(posedge wclk)
    if (accept) ring[wptr] <= wr_data;

  // ---------------- read domain ----------------
  logic [1:0]       rrs;
  logic             r_rst_n;
  logic [DEPTH-1:0] rtog, full_m, full_s, occ, mv;
  logic [DW-1:0]    sdat [DEPTH];
  logic [AW-1:0]    rptr, rnext;
  logic             pull, ov;
  logic [DW-1:0]    od;

  always_ff @(posedge rclk or negedge rrst_n)
    if (!rrst_n) rrs <= '0;
    else         rrs <= {rrs[0], 1'b1};
  assign r_rst_n = rrs[1];

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_adv
      if (g == LAST) begin : g_tail
        assign mv[g] = occ[g];
      end else begin : g_body
        assign mv[g] = occ[g] & (~occ[g+1] | mv[g+1]);
      end
    end
  endgenerate

  assign rnext = (rptr == TOP) ? '0 : rptr + 1'b1;
  assign pull  = (full_s[rptr] ^ rtog[rptr]) & (~occ[0] | mv[0]);

  always_ff @(posedge rclk or negedge r_rst_n)
    if (!r_rst_n) begin
      rptr     <= '0;
      rtog     <= '0;
      full_m   <= '0;
      full_s   <= '0;
      occ      <= '0;
      ov       <= 1'b0;
      od       <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      full_m <= wtog;
      full_s <= full_m;
      occ[0] <= pull | (occ[0] & ~mv[0]);
      for (int i = 1; i < DEPTH; i++)
        occ[i] <= mv[i-1] | (occ[i] & ~mv[i]);
      if (pull) begin
        rtog[rptr] <= ~rtog[rptr];
        rptr       <= rnext;
      end
      ov       <= mv[LAST];
      od       <= sdat[LAST];
      rd_valid <= ov;
      rd_data  <= od;
    end

  always_ff @(posedge rclk) begin
    if (pull) sdat[0] <= ring[rptr];
    for (int i = 1; i < DEPTH; i++)
      if (mv[i-1]) sdat[i] <= sdat[i-1];
  end

endmodule

// File: rtl/xclk_stage_fifo_chk.sv
module xclk_stage_fifo_chk #(
  parameter int DEPTH = 3
) (
  input logic             wclk,
  input logic             rclk,
  input logic             w_rst_n,
  input logic             r_rst_n,
  input logic             wr_en,
  input logic             wr_nen,
  input logic             wr_ready,
  input logic             pend,
  input logic             space_now,
  input logic [DEPTH-1:0] occ,
  input logic [DEPTH-1:0] mv,
  input logic             pull,
  input logic             rd_valid
);
  AST_STROBE_EXCL: assert property (@(posedge wclk) disable iff (!w_rst_n)
    !(wr_en && wr_nen)); // R8

  AST_WRITE_INTO_FREE: assert property (@(posedge wclk) disable iff (!w_rst_n)
    wr_en |-> space_now); // R8

  AST_READY_ONE_CYCLE: assert property (@(posedge wclk) disable iff (!w_rst_n)
    wr_ready |=> !wr_ready); // R3

  AST_READY_HAS_CAUSE: assert property (@(posedge wclk) disable iff (!w_rst_n)
    wr_ready |-> $past(wr_en || wr_nen || pend, 2)); // R5

  AST_STAGE_CONSERVE: assert property (@(posedge rclk) disable iff (!r_rst_n)
    1'b1 |=> int'($countones(occ)) ==
             int'($past($countones(occ))) + int'($past(pull)) - int'($past(mv[DEPTH-1]))); // R9

  AST_VALID_FROM_TAIL: assert property (@(posedge rclk) disable iff (!r_rst_n)
    rd_valid |-> $past(occ[DEPTH-1], 2)); // R7
endmodule

bind xclk_stage_fifo xclk_stage_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .wclk(wclk), .rclk(rclk), .w_rst_n(w_rst_n), .r_rst_n(r_rst_n),
  .wr_en(wr_en), .wr_nen(wr_nen), .wr_ready(wr_ready), .pend(pend),
  .space_now(space_now), .occ(occ), .mv(mv), .pull(pull), .rd_valid(rd_valid)
);

// File: tb/xclk_stage_fifo_bench.sv
module xclk_stage_fifo_bench;
  localparam int DW = 32;
  localparam int WPER = 10;

  logic wclk = 0, rclk = 0;
  logic wrst_n = 0, rrst_n = 0;
  logic wr_en = 0, wr_nen = 0;
  logic [DW-1:0] wr_data = '0;
  logic wr_ready, rd_valid;
  logic [DW-1:0] rd_data;
  int rhalf = 3;

  always #(WPER/2) wclk = ~wclk;
  always #(rhalf) rclk = ~rclk;

  xclk_stage_fifo #(.DW(DW), .DEPTH(3)) u_xclk_stage_fifo (
    .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .wr_nen(wr_nen),
    .wr_data(wr_data), .wr_ready(wr_ready),
    .rclk(rclk), .rrst_n(rrst_n), .rd_valid(rd_valid), .rd_data(rd_data));

  int compared = 0, mismatched = 0;
  logic [DW-1:0] q[$];
  int sent = 0, rx = 0, b2b = 0, late = 0;
  int wcyc = 0, scyc = 0;
  bit perm = 0, owed = 0, exact = 0, prev_rdy = 0, prev_v = 0, live = 0;
  string etag = "R3";

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  always @(negedge rclk) if (live) begin
    if (rd_valid) begin
      check(q.size() > 0, "R6", "valid with nothing outstanding", 1, 0);
      if (q.size() > 0) begin
        check(rd_data == q[0], "R6", "word value/order", rd_data, q[0]);
        void'(q.pop_front());
      end
      rx++;
      if (prev_v) b2b++;
    end
    prev_v = rd_valid;
  end

  task automatic wtick();
    @(negedge wclk);
    wcyc++;
    if (wr_ready) begin
      check(owed, "R5", "ready without a strobe", 1, 0);
      check(wcyc - scyc >= 2, "R5", "ready latency too short", wcyc - scyc, 2);
      if (exact) check(wcyc - scyc == 2, etag, "ready latency", wcyc - scyc, 2);
      check(!prev_rdy, "R3", "ready wider than one cycle", 2, 1);
      if (wcyc - scyc > 2) late++;
      owed = 0; exact = 0; perm = 1;
    end else begin
      if (owed && exact && wcyc - scyc == 2)
        check(0, etag, "ready missing at second cycle", 0, 1);
      if (owed && exact && wcyc - scyc == 2) exact = 0;
      if (!owed) compared++; // no spurious ready this cycle (R5)
    end
    prev_rdy = wr_ready;
    wr_en = 0; wr_nen = 0;
  endtask

  task automatic strobe(input bit is_en, input logic [DW-1:0] d,
                        input bit ex, input string tag);
    while (!perm) wtick();
    perm = 0; owed = 1; exact = ex; etag = tag; scyc = wcyc;
    if (is_en) begin
      wr_en = 1; wr_data = d; q.push_back(d); sent++;
    end else begin
      wr_nen = 1; wr_data = 32'hDEAD_BEEF;
    end
    wtick();
  endtask

  initial begin
    repeat (3) @(negedge wclk);
    check(wr_ready == 0, "R10", "wr_ready in reset", wr_ready, 0);
    check(rd_valid == 0, "R10", "rd_valid in reset", rd_valid, 0);
    wrst_n = 1; rrst_n = 1;
    repeat (4) @(negedge wclk);
    live = 1;
    check(wr_ready == 0, "R1", "wr_ready after reset", wr_ready, 0);
    check(rd_valid == 0, "R1", "rd_valid after reset", rd_valid, 0);
    perm = 1;
    strobe(1, 32'hA5A5_0001, 1, "R3");
    repeat (30) wtick();
    strobe(0, '0, 1, "R4");
    repeat (10) wtick();
    for (int i = 0; i < 24; i++) begin
      if (i % 3 == 2) strobe(0, '0, 0, "R8");
      else strobe(1, 32'h1000_0000 + i, 0, "R2");
    end
    repeat (40) wtick();
    check(q.size() == 0, "R2", "words outstanding after mixed strobes", q.size(), 0);
    rhalf = 40;
    repeat (20) wtick();
    for (int i = 0; i < 8; i++) strobe(1, 32'h2000_0000 + i * 7, 0, "R9");
    while (owed) wtick();
    repeat (400) wtick();
    check(late > 0, "R5", "pending ready observed", late, 1);
    check(b2b > 0, "R7", "consecutive read words", b2b, 1);
    check(q.size() == 0, "R9", "words lost under back-pressure", q.size(), 0);
    rhalf = 3;
    repeat (20) wtick();
    check(rx == sent, "R6", "words received", rx, sent);
    check(owed == 0, "R5", "unanswered strobe", owed, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge wclk);
    compared++; mismatched++;
    $display("FAIL watchdog: run hung actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule